// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Controller

This block sits between a clocked host and an asynchronous static RAM with a 19-bit address, an 8-bit data bus and three active-low strobes: chip select, write enable and output enable. The host issues one word at a time. A request is a single-cycle `req` pulse taken while `ready` is high, carrying the address, the write flag and, for writes, the data. The controller then plays out the matching strobe sequence on registered pins and returns read data with a one-cycle valid strobe.

Every analogue timing minimum of the RAM is a nanosecond parameter. Each one is turned into a clock count at elaboration from the clock period parameter, so the same RTL serves any clock rate. The RAM's data pins are split into an output value, an output enable for the pad driver and an input value. Between requests the RAM is left deselected, in standby, with the bus floating.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `rdata_valid` is 0 and `ready` is 1.
- R2: Whenever `sram_cs_n` is 1, `sram_we_n` and `sram_oe_n` are 1 and `sram_dq_oe` is 0. Whenever `ready` is 1, `sram_cs_n` is 1, so the RAM stays in standby between requests.
- R3: A read accepted at clock edge k holds `sram_cs_n`=0, `sram_oe_n`=0, `sram_we_n`=1 and `sram_addr` equal to the request address for NACC cycles. Here NACC = max(ceil(T_AA_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)). At edge k+NACC, `sram_dq_i` is registered into `rdata`, and `rdata_valid` is 1 for exactly that one cycle.
- R4: A write accepted at edge k drives these pins. In cycle 0 (after edge k), `sram_cs_n`=0 and `sram_we_n`=1. In cycles 1..NP, `sram_we_n`=0. In cycle NP+1, `sram_we_n`=1 and `sram_cs_n` is still 0. From cycle NP+2, the RAM is in standby. NP = max(ceil(T_WP_NS/CLK_NS), ceil(T_AW_NS/CLK_NS)-1, ceil(T_CW_NS/CLK_NS)-1, ceil(T_DW_NS/CLK_NS)-1). Throughout cycles 0..NP+1, `sram_oe_n`=1, `sram_dq_oe`=1 and `sram_dq_o` is the request data.
- R5: `sram_dq_oe` is 1 only while `sram_oe_n` is 1 and `sram_cs_n` is 0.
- R6: `sram_addr` changes only at a clock edge before which `sram_cs_n` or `sram_we_n` was 1.
- R7: `ready` is 0 from the cycle after acceptance until the sequence ends. Two acceptances are at least NCYC = ceil(T_RC_NS/CLK_NS) edges apart. A write returns `ready` in cycle max(NP+2, NCYC-1), and a read returns it in cycle max(NACC+NHZ+1, NCYC-1).
- R8: After `sram_oe_n` rises at the end of a read, the controller waits NHZ = ceil(T_HZ_NS/CLK_NS) turnaround cycles, with the bus released, before it accepts another request. `sram_dq_oe` therefore cannot rise within NHZ cycles of `sram_oe_n` rising.
- R9: Every count is the ceiling of the nanosecond minimum divided by CLK_NS, with a floor of 1. With the defaults (10 ns clock), NACC=6, NP=4, NHZ=2 and NCYC=6.
- R10: A `req` held high while `ready` is 0 is ignored. No new strobe sequence starts, and `sram_addr` keeps the accepted address into the first standby cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, taken when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller can accept a request this cycle |
| rdata | output | DATA_W | Last captured read data |
| rdata_valid | output | 1 | One-cycle strobe when `rdata` is updated |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | DATA_W | Value driven onto the RAM data pins |
| sram_dq_oe | output | 1 | Pad driver enable for the data pins |
| sram_dq_i | input | DATA_W | Value read from the RAM data pins |

## Verification
All pins are registered. For a request accepted at edge k, each result is due a fixed number of cycles later when counted from k:
- For writes, write enable is low from the cycle after k+1 through the cycle after k+NP, and `ready` returns in cycle max(NP+2, NCYC-1).
- For reads, data is captured at edge k+NACC, so `rdata_valid` is seen in cycle NACC, and `ready` returns in cycle max(NACC+NHZ+1, NCYC-1).

The bench computes these positions from the formulas in R4, R3 and R7. It drives a request at a falling edge and then compares every pin at each following falling edge against the value due in that cycle. A bench-side RAM model latches data on the rising write-enable edge, so a misplaced strobe shows up when the data is read back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ_ACCESS,
      ST_READ_CAPTURE,
      ST_WRITE_SETUP,
      ST_WRITE_PULSE,
      ST_WRITE_RECOVER,
      ST_BUS_TURNAROUND
   } ctl_state_e;

   // Strobe set applied to the RAM pins on the next edge
   typedef struct packed {
      logic cs_n;
      logic we_n;
      logic oe_n;
      logic drive;
   } pin_ctl_t;

   localparam pin_ctl_t PIN_STANDBY = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

   // Clock count covering a minimum time, never less than one cycle
   function automatic int ns_to_ticks(input int ns, input int clk_ns);
      int t;
      t = (ns + clk_ns - 1) / clk_ns;
      return (t < 1) ? 1 : t;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int CLK_NS  = 10,
   parameter int T_RC_NS = 55,
   parameter int T_AA_NS = 55,
   parameter int T_OE_NS = 25,
   parameter int T_HZ_NS = 20,
   parameter int T_WP_NS = 35,
   parameter int T_CW_NS = 40,
   parameter int T_AW_NS = 40,
   parameter int T_DW_NS = 25
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req,
   input  logic     req_write,
   output logic     ready,
   output logic     latch,
   output logic     capture,
   output pin_ctl_t ctl_next
);
   localparam int N_ACC = imax(ns_to_ticks(T_AA_NS, CLK_NS), ns_to_ticks(T_OE_NS, CLK_NS));
   localparam int N_CYC = ns_to_ticks(T_RC_NS, CLK_NS);
   localparam int N_HZ  = ns_to_ticks(T_HZ_NS, CLK_NS);
   // The setup cycle already counts toward the address, select and data windows
   localparam int N_PUL = imax(ns_to_ticks(T_WP_NS, CLK_NS),
                          imax(ns_to_ticks(T_AW_NS, CLK_NS) - 1,
                          imax(ns_to_ticks(T_CW_NS, CLK_NS) - 1,
                               ns_to_ticks(T_DW_NS, CLK_NS) - 1)));
   localparam int N_MAX = imax(imax(N_ACC, N_CYC), imax(N_HZ, N_PUL));
   localparam int TW    = $clog2(N_MAX + 1);
   localparam int NTMR  = 2;   // 0: phase timer, 1: cycle-time timer

   localparam logic [TW-1:0] V_ACC = TW'(N_ACC - 1);
   localparam logic [TW-1:0] V_CYC = TW'(N_CYC - 1);
   localparam logic [TW-1:0] V_HZ  = TW'(N_HZ - 1);
   localparam logic [TW-1:0] V_PUL = TW'(N_PUL - 1);

   ctl_state_e      st_q, st_d;
   logic [NTMR-1:0] t_load, t_done;
   logic [TW-1:0]   t_val [NTMR];

   for (genvar g = 0; g < NTMR; g++) begin : g_tmr
      sram_ctrl_timer #(.W(TW)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (t_load[g]),
         .load_val (t_val[g]),
         .done     (t_done[g])
      );
   end

   assign ready = (st_q == ST_IDLE) && t_done[1];

   always_comb begin
      st_d     = st_q;
      t_load   = '0;
      t_val[0] = '0;
      t_val[1] = V_CYC;
      ctl_next = PIN_STANDBY;
      latch    = 1'b0;
      capture  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (req && ready) begin
               latch         = 1'b1;
               t_load[1]     = 1'b1;
               ctl_next.cs_n = 1'b0;
               if (req_write) begin
                  st_d           = ST_WRITE_SETUP;
                  ctl_next.drive = 1'b1;
               end else begin
                  st_d          = ST_READ_ACCESS;
                  ctl_next.oe_n = 1'b0;
                  t_load[0]     = 1'b1;
                  t_val[0]      = V_ACC;
               end
            end
         end
         ST_READ_ACCESS: begin
            if (t_done[0]) begin
               st_d    = ST_READ_CAPTURE;
               capture = 1'b1;
            end else begin
               ctl_next.cs_n = 1'b0;
               ctl_next.oe_n = 1'b0;
            end
         end
         ST_READ_CAPTURE: begin
            st_d      = ST_BUS_TURNAROUND;
            t_load[0] = 1'b1;
            t_val[0]  = V_HZ;
         end
         ST_BUS_TURNAROUND: begin
            if (t_done[0])
               st_d = ST_IDLE;
         end
         ST_WRITE_SETUP: begin
            st_d           = ST_WRITE_PULSE;
            t_load[0]      = 1'b1;
            t_val[0]       = V_PUL;
            ctl_next.cs_n  = 1'b0;
            ctl_next.we_n  = 1'b0;
            ctl_next.drive = 1'b1;
         end
         ST_WRITE_PULSE: begin
            ctl_next.cs_n  = 1'b0;
            ctl_next.drive = 1'b1;
            if (t_done[0])
               st_d = ST_WRITE_RECOVER;
            else
               ctl_next.we_n = 1'b0;
         end
         ST_WRITE_RECOVER: begin
            st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= ST_IDLE;
      else
         st_q <= st_d;
   end
endmodule

// File: rtl/sram_ctrl_pads.sv
module sram_ctrl_pads
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch,
   input  logic              capture,
   input  pin_ctl_t          ctl_next,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] sram_dq_i,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_valid
);
   pin_ctl_t          ctl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdat_q, rdat_q;
   logic              rval_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= PIN_STANDBY;
         addr_q <= '0;
         wdat_q <= '0;
         rdat_q <= '0;
         rval_q <= 1'b0;
      end else begin
         ctl_q  <= ctl_next;
         rval_q <= capture;
         if (latch) begin
            addr_q <= req_addr;
            wdat_q <= req_wdata;
         end
         if (capture)
            rdat_q <= sram_dq_i;
      end
   end

   assign sram_addr   = addr_q;
   assign sram_cs_n   = ctl_q.cs_n;
   assign sram_we_n   = ctl_q.we_n;
   assign sram_oe_n   = ctl_q.oe_n;
   assign sram_dq_oe  = ctl_q.drive;
   assign sram_dq_o   = wdat_q;
   assign rdata       = rdat_q;
   assign rdata_valid = rval_q;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int DATA_W  = 8,
   parameter int CLK_NS  = 10,
   parameter int T_RC_NS = 55,
   parameter int T_AA_NS = 55,
   parameter int T_OE_NS = 25,
   parameter int T_HZ_NS = 20,
   parameter int T_WP_NS = 35,
   parameter int T_CW_NS = 40,
   parameter int T_AW_NS = 40,
   parameter int T_DW_NS = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_valid,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_cs_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_i
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_async_ctrl: ADDR_W and DATA_W must be positive");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_async_ctrl: CLK_NS must be at least 1");
   end
   if (T_RC_NS < 0 || T_AA_NS < 0 || T_OE_NS < 0 || T_HZ_NS < 0 ||
       T_WP_NS < 0 || T_CW_NS < 0 || T_AW_NS < 0 || T_DW_NS < 0) begin : g_bad_time
      $error("sram_async_ctrl: timing minimums must not be negative");
   end

   logic     latch, capture;
   pin_ctl_t ctl_next;

   sram_ctrl_fsm #(
      .CLK_NS (CLK_NS),  .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
      .T_OE_NS(T_OE_NS), .T_HZ_NS(T_HZ_NS), .T_WP_NS(T_WP_NS),
      .T_CW_NS(T_CW_NS), .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_write (req_write),
      .ready     (ready),
      .latch     (latch),
      .capture   (capture),
      .ctl_next  (ctl_next)
   );

   sram_ctrl_pads #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
      .clk         (clk),
      .rst_n       (rst_n),
      .latch       (latch),
      .capture     (capture),
      .ctl_next    (ctl_next),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .sram_dq_i   (sram_dq_i),
      .sram_addr   (sram_addr),
      .sram_cs_n   (sram_cs_n),
      .sram_we_n   (sram_we_n),
      .sram_oe_n   (sram_oe_n),
      .sram_dq_o   (sram_dq_o),
      .sram_dq_oe  (sram_dq_oe),
      .rdata       (rdata),
      .rdata_valid (rdata_valid)
   );
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int CLK_NS  = 10,
   parameter int T_RC_NS = 55,
   parameter int T_HZ_NS = 20,
   parameter int T_WP_NS = 35
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              ready,
   input logic              rdata_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_cs_n,
   input logic              sram_we_n,
   input logic              sram_oe_n,
   input logic              sram_dq_oe
);
   localparam logic [7:0] L_WP  = 8'(ns_to_ticks(T_WP_NS, CLK_NS));
   localparam logic [7:0] L_HZ  = 8'(ns_to_ticks(T_HZ_NS, CLK_NS));
   localparam logic [7:0] L_GAP = 8'(ns_to_ticks(T_RC_NS, CLK_NS) - 1);

   logic [7:0] we_low, oe_high, acc_gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_low  <= '0;
         oe_high <= 8'hFF;
         acc_gap <= 8'hFF;
      end else begin
         we_low  <= sram_we_n ? 8'd0 : ((we_low == 8'hFF) ? we_low : we_low + 8'd1);
         oe_high <= !sram_oe_n ? 8'd0 : ((oe_high == 8'hFF) ? oe_high : oe_high + 8'd1);
         if (req && ready)
            acc_gap <= 8'd0;
         else if (acc_gap != 8'hFF)
            acc_gap <= acc_gap + 8'd1;
      end
   end

   assert_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sram_cs_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe));

   assert_ready_standby_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> sram_cs_n);

   assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid |=> !rdata_valid);

   assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (!sram_cs_n && sram_oe_n && sram_dq_oe));

   assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (we_low >= L_WP));

   assert_drive_oe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> (sram_oe_n && !sram_cs_n));

   assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sram_addr) |-> ($past(sram_cs_n) || $past(sram_we_n)));

   assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready);

   assert_cycle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |-> (acc_gap >= L_GAP));

   assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_dq_oe) |-> (oe_high >= L_HZ));
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
   .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS),
   .T_HZ_NS(T_HZ_NS), .T_WP_NS(T_WP_NS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req         (req),
   .ready       (ready),
   .rdata_valid (rdata_valid),
   .sram_addr   (sram_addr),
   .sram_cs_n   (sram_cs_n),
   .sram_we_n   (sram_we_n),
   .sram_oe_n   (sram_oe_n),
   .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
   localparam int AW = 19;
   localparam int DW = 8;
   localparam int CLK = 10;

   function automatic int cd(input int ns);
      int t;
      t = (ns + CLK - 1) / CLK;
      return (t < 1) ? 1 : t;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // R9: counts derived from the nanosecond minimums
   localparam int NACC = mx(cd(55), cd(25));
   localparam int NCYC = cd(55);
   localparam int NHZ  = cd(20);
   localparam int NP   = mx(cd(35), mx(cd(40) - 1, mx(cd(40) - 1, cd(25) - 1)));
   localparam int W_RDY = mx(NP + 2, NCYC - 1);
   localparam int R_RDY = mx(NACC + NHZ + 1, NCYC - 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ready, rdata_valid;
   logic [DW-1:0] rdata, sram_dq_o, sram_dq_i;
   logic [AW-1:0] sram_addr;
   logic          sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #5 clk = ~clk;

   sram_async_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
      .rdata(rdata), .rdata_valid(rdata_valid), .sram_addr(sram_addr),
      .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
   );

   // RAM model: latches on the rising write strobe, drives only in read mode
   logic [DW-1:0] mdl [64];
   initial for (int i = 0; i < 64; i++) mdl[i] = '0;
   always @(posedge sram_we_n) if (sram_cs_n === 1'b0) mdl[sram_addr[5:0]] = sram_dq_o;
   assign sram_dq_i = (!sram_cs_n && !sram_oe_n && sram_we_n) ? mdl[sram_addr[5:0]] : '0;

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired got %0d cycles exp fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] pins();
      return 32'({sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ready, rdata_valid});
   endfunction
   function automatic logic [31:0] mkp(input bit cs, we, oe, dv, rd, rv);
      return 32'({cs, we, oe, dv, rd, rv});
   endfunction

   function automatic logic [AW-1:0] addr_of(input int i);
      return {13'((i * 197) ^ 'h15A5), 6'(i)};
   endfunction
   function automatic logic [DW-1:0] data_of(input int i, input bit inv);
      logic [DW-1:0] v;
      v = 8'(i * 37 + 11);
      return inv ? ~v : v;
   endfunction

   task automatic wait_ready();
      while (ready !== 1'b1) @(negedge clk);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit junk);
      wait_ready();
      req = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      for (int c = 0; c <= W_RDY; c++) begin
         @(negedge clk);
         // R4 R9: setup, NP low cycles, recover, standby
         chk($sformatf("R4 R9 write pins c=%0d", c), pins(),
             mkp(c > NP + 1, !(c >= 1 && c <= NP), 1'b1, c <= NP + 1, c >= W_RDY, 1'b0));
         chk($sformatf("R6 write addr c=%0d", c), 32'(sram_addr), 32'(a));
         if (c <= NP + 1) chk($sformatf("R4 write data c=%0d", c), 32'(sram_dq_o), 32'(d));
         if (c == 0) begin
            if (junk) begin req_write = 1'b0; req_addr = ~a; end
            else req = 1'b0;
         end
         if (c == W_RDY) req = 1'b0;
      end
      if (junk) begin
         @(negedge clk);
         // R10: the held request was not taken
         chk("R10 ignored request write", pins(), mkp(1, 1, 1, 0, 1, 0));
         chk("R10 addr kept write", 32'(sram_addr), 32'(a));
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit junk);
      wait_ready();
      req = 1'b1; req_write = 1'b0; req_addr = a;
      for (int c = 0; c <= R_RDY; c++) begin
         @(negedge clk);
         // R3 R8 R7: access window, capture pulse, turnaround, ready
         chk($sformatf("R3 R8 read pins c=%0d", c), pins(),
             mkp(c >= NACC, 1'b1, c >= NACC, 1'b0, c >= R_RDY, c == NACC));
         chk($sformatf("R6 read addr c=%0d", c), 32'(sram_addr), 32'(a));
         if (c == NACC) chk("R3 read data", 32'(rdata), 32'(d));
         if (c == 0) begin
            if (junk) begin req_write = 1'b1; req_addr = ~a; end
            else req = 1'b0;
         end
         if (c == R_RDY) req = 1'b0;
      end
      if (junk) begin
         @(negedge clk);
         chk("R10 ignored request read", pins(), mkp(1, 1, 1, 0, 1, 0));
         chk("R10 addr kept read", 32'(sram_addr), 32'(a));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset pins", pins(), mkp(1, 1, 1, 0, 1, 0));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", pins(), mkp(1, 1, 1, 0, 1, 0));
      chk("R2 idle standby", 32'(sram_cs_n), 32'(1));

      for (int i = 0; i < 64; i++) do_write(addr_of(i), data_of(i, 0), (i % 8) == 3);
      for (int i = 0; i < 64; i++) do_read(addr_of(i), data_of(i, 0), (i % 8) == 5);
      // R8: alternating writes right after reads
      for (int i = 0; i < 16; i++) begin
         do_write(addr_of(i), data_of(i, 1), 1'b0);
         do_read(addr_of(i), data_of(i, 1), 1'b0);
      end

      repeat (4) @(negedge clk);
      chk("R2 final standby", pins(), mkp(1, 1, 1, 0, 1, 0));
      summary();
      $finish;
   end
endmodule